// File: doc/BRIEF.md
# Raster Scan Timing Generator

This block keeps track of where a video raster is. It counts pixel clocks along a scan line and scan lines down a field, with both totals set by software. It also keeps an odd/even field flag that flips at every field wrap when interlace is on. From that position it builds a status word. The word holds the current line and the field parity, and it encodes the sync, porch and display-active regions as the rest of the system sees them. It also raises a one-cycle frame strobe when the raster enters the line where vertical retrace ends.

The block runs on the pixel clock. Four configuration registers are loaded through a simple write port: total, sync-config, sync-time and horizontal-position. The current line and pixel counters, the status word and the strobe are outputs. The status word encodes regions differently on lines whose low bit matches the field flag and on lines whose low bit does not. This is how the two interleaved line sets of an interlaced picture are told apart.

Top module: `raster_timing`

## Requirements
- R1: While reset is held and in the cycle after, `line_o`, `dot_o`, `status_o` and `frame_o` are all zero and the field flag is even.
- R2: `dot_o` goes up by one per clock. In the cycle after it equals the dot limit (bits 9:0 of the total register, select 0), it returns to 0 and `line_o` goes up by one. In the cycle after `line_o` equals or exceeds the line limit (bits 25:16 of the total register), it returns to 0. Every other bit of the total register is discarded.
- R3: Bit 4 of the sync-config register (select 1) turns interlace on. With interlace on, the field flag inverts each time the line counter wraps to 0. With interlace off, the field flag never changes.
- R4: `status_o` is registered one cycle behind the counters. Bits 9:0 hold the line of the previous cycle and bit 10 holds its field flag (1 = odd).
- R5: A line whose bit 0 equals the field flag is a matching line. On a matching line, bit 12 (hsync inactive) is set while the pixel position is greater than 2*(sync-time bits 6:0 + 1) (select 2). When the line is also at or beyond the vsync length (sync-time bits 11:8), bit 13 (vsync inactive) is set. In that case bit 11 (display active) is set while the pixel position is greater than the horizontal-position bits 9:0 + 1 (select 3).
- R6: On a line whose bit 0 differs from the field flag, only bit 12 is set before the vsync length. From the vsync length on, bits 12 and 13 are set, and bit 11 is set while pixel position + BACK_PORCH is less than the line length (dot limit + 1).
- R7: `frame_o` is high for exactly one cycle. That cycle is the first one in which `line_o` shows RETRACE_END (default 42) after counting up from the line before it.
- R8: After reset the line limit is 624, the dot limit is 863, the vsync length is 5 lines, the hsync field is 63 (width 128 dots), the front-porch field is 0 and interlace is off.
- R9: A write to the total register sets `dot_o` to 0 on the next cycle. `line_o` and the field flag keep their values.
- R10: When the dot limit is 0, the line counter, the pixel counter and the field flag hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 total, 1 sync-config, 2 sync-time, 3 horizontal-position |
| wr_data | input | 32 | Register write data |
| line_o | output | 10 | Current line counter |
| dot_o | output | 10 | Current pixel counter |
| status_o | output | 16 | Sync-status word (bits 15:14 zero) |
| frame_o | output | 1 | Strobe on entering the retrace end line |

## Verification
A register write takes effect at the clock edge that samples it. The counters and `frame_o` change at that same edge, and `status_o` changes one edge later, because it encodes the counters of the cycle before. A reference model steps at each rising edge with the same write inputs. At every edge it queues the expected counters and strobe, together with the status it computes from its own state before that edge. A monitor compares each queued item at the next falling edge. Separate directed checks count the field flips and strobes over fixed windows of whole fields. They also cover the reset defaults, a mid-line total rewrite and a frozen line.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int DOT_W    = 10;
  localparam int LINE_W   = 10;
  localparam int DATA_W   = 32;
  localparam int STATUS_W = 16;

  typedef enum logic [1:0] {
    SEL_TOTAL    = 2'd0,
    SEL_SYNCCFG  = 2'd1,
    SEL_SYNCTIME = 2'd2,
    SEL_HPOS     = 2'd3
  } reg_sel_e;

  localparam int ST_FIELD     = 10;
  localparam int ST_ACTIVE    = 11;
  localparam int ST_HSYNC_OFF = 12;
  localparam int ST_VSYNC_OFF = 13;

  localparam logic [DATA_W-1:0] RST_TOTAL    = 32'h0270_035F;
  localparam logic [DATA_W-1:0] RST_SYNCTIME = 32'h07D6_A53F;

  typedef struct packed {
    logic [LINE_W-1:0] line_max;
    logic [DOT_W-1:0]  dot_max;
    logic              interlace;
    logic [3:0]        vs_lines;
    logic [6:0]        hs_half;
    logic [DOT_W-1:0]  fp_dots;
  } raster_cfg_t;
endpackage

// File: rtl/raster_cfg_regs.sv
module raster_cfg_regs
  import raster_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output raster_cfg_t       cfg_o,
  output logic              total_wr_o
);
  raster_cfg_t cfg_q;

  assign total_wr_o = wr_en && (wr_sel == SEL_TOTAL);
  assign cfg_o      = cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.line_max  <= RST_TOTAL[16 +: LINE_W];
      cfg_q.dot_max   <= RST_TOTAL[0 +: DOT_W];
      cfg_q.interlace <= 1'b0;
      cfg_q.vs_lines  <= RST_SYNCTIME[11:8];
      cfg_q.hs_half   <= RST_SYNCTIME[6:0];
      cfg_q.fp_dots   <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_TOTAL: begin
          cfg_q.line_max <= wr_data[16 +: LINE_W];
          cfg_q.dot_max  <= wr_data[0 +: DOT_W];
        end
        SEL_SYNCCFG:  cfg_q.interlace <= wr_data[4];
        SEL_SYNCTIME: begin
          cfg_q.vs_lines <= wr_data[11:8];
          cfg_q.hs_half  <= wr_data[6:0];
        end
        default:      cfg_q.fp_dots <= wr_data[0 +: DOT_W];
      endcase
    end
  end
endmodule

// File: rtl/raster_counters.sv
module raster_counters
  import raster_pkg::*;
#(
  parameter int RETRACE_END = 42
) (
  input  logic              clk,
  input  logic              rst,
  input  raster_cfg_t       cfg,
  input  logic              total_wr,
  output logic [DOT_W-1:0]  dot_o,
  output logic [LINE_W-1:0] line_o,
  output logic              field_o,
  output logic              frame_o
);
  localparam logic [LINE_W-1:0] END_LINE = LINE_W'(RETRACE_END);

  logic [DOT_W-1:0]  dot_q, dot_n;
  logic [LINE_W-1:0] line_q, line_n;
  logic              field_q, field_n, hit;

  always_comb begin
    dot_n   = dot_q;
    line_n  = line_q;
    field_n = field_q;
    hit     = 1'b0;
    if (total_wr) begin
      dot_n = '0;
    end else if (cfg.dot_max != '0) begin
      if (dot_q >= cfg.dot_max) begin
        dot_n = '0;
        if (line_q >= cfg.line_max) begin
          line_n = '0;
          if (cfg.interlace) field_n = ~field_q;
        end else begin
          line_n = line_q + LINE_W'(1);
          hit    = (line_q + LINE_W'(1)) == END_LINE;
        end
      end else begin
        dot_n = dot_q + DOT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dot_q   <= '0;
      line_q  <= '0;
      field_q <= 1'b0;
      frame_o <= 1'b0;
    end else begin
      dot_q   <= dot_n;
      line_q  <= line_n;
      field_q <= field_n;
      frame_o <= hit;
    end
  end

  assign dot_o   = dot_q;
  assign line_o  = line_q;
  assign field_o = field_q;
endmodule

// File: rtl/raster_status_enc.sv
module raster_status_enc
  import raster_pkg::*;
#(
  parameter int BACK_PORCH = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  raster_cfg_t         cfg,
  input  logic [LINE_W-1:0]   line_i,
  input  logic [DOT_W-1:0]    dot_i,
  input  logic                field_i,
  output logic [STATUS_W-1:0] status_o
);
  localparam int CW = DOT_W + 2;

  logic [CW-1:0]       dot_x, hs_width, fp_width, line_len, dot_plus_bp;
  logic                past_vs, matching;
  logic [STATUS_W-1:0] st;

  always_comb begin
    dot_x       = CW'(dot_i);
    hs_width    = (CW'(cfg.hs_half) + CW'(1)) << 1;
    fp_width    = CW'(cfg.fp_dots) + CW'(1);
    line_len    = CW'(cfg.dot_max) + CW'(1);
    dot_plus_bp = dot_x + CW'(BACK_PORCH);
    past_vs     = line_i >= LINE_W'(cfg.vs_lines);
    matching    = line_i[0] == field_i;

    st = '0;
    st[LINE_W-1:0] = line_i;
    st[ST_FIELD]   = field_i;
    if (matching) begin
      st[ST_HSYNC_OFF] = dot_x > hs_width;
      if (past_vs) begin
        st[ST_VSYNC_OFF] = 1'b1;
        st[ST_ACTIVE]    = dot_x > fp_width;
      end
    end else begin
      st[ST_HSYNC_OFF] = 1'b1;
      if (past_vs) begin
        st[ST_VSYNC_OFF] = 1'b1;
        st[ST_ACTIVE]    = dot_plus_bp < line_len;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) status_o <= '0;
    else     status_o <= st;
  end
endmodule

// File: rtl/raster_timing.sv
module raster_timing
  import raster_pkg::*;
#(
  parameter int RETRACE_END = 42,
  parameter int BACK_PORCH  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [LINE_W-1:0]   line_o,
  output logic [DOT_W-1:0]    dot_o,
  output logic [STATUS_W-1:0] status_o,
  output logic                frame_o
);
  raster_cfg_t cfg;
  logic        total_wr;
  logic        field;

  raster_cfg_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cfg_o(cfg), .total_wr_o(total_wr)
  );

  raster_counters #(.RETRACE_END(RETRACE_END)) u_cnt (
    .clk(clk), .rst(rst), .cfg(cfg), .total_wr(total_wr),
    .dot_o(dot_o), .line_o(line_o), .field_o(field), .frame_o(frame_o)
  );

  raster_status_enc #(.BACK_PORCH(BACK_PORCH)) u_stat (
    .clk(clk), .rst(rst), .cfg(cfg), .line_i(line_o), .dot_i(dot_o),
    .field_i(field), .status_o(status_o)
  );
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int RETRACE_END = 42
) (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [9:0]  dot_max,
  input logic        interlace,
  input logic        field,
  input logic [9:0]  line_o,
  input logic [9:0]  dot_o,
  input logic [15:0] status_o,
  input logic        frame_o
);
  AST_DOT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && wr_sel == 2'd0) && dot_max != 10'd0 && dot_o < dot_max) |=> dot_o == 10'($past(dot_o) + 10'd1)); // R2
  AST_FIELD_FLIP: assert property (@(posedge clk) disable iff (rst)
    (field != $past(field)) |-> (line_o == 10'd0 && $past(interlace))); // R3
  AST_STATUS_LINE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> status_o[9:0] == $past(line_o)); // R4
  AST_STROBE_AT_END: assert property (@(posedge clk) disable iff (rst)
    frame_o |-> line_o == 10'(RETRACE_END)); // R7
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    frame_o |=> !frame_o); // R7
  AST_TOTAL_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd0) |=> (dot_o == 10'd0 && $stable(line_o) && $stable(field))); // R9
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (dot_max == 10'd0 && !wr_en) |=> ($stable(dot_o) && $stable(line_o) && $stable(field))); // R10
endmodule

bind raster_timing raster_timing_chk #(.RETRACE_END(RETRACE_END)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
  .dot_max(cfg.dot_max), .interlace(cfg.interlace), .field(field),
  .line_o(line_o), .dot_o(dot_o), .status_o(status_o), .frame_o(frame_o)
);

// File: tb/tb_raster_timing.sv
module tb_raster_timing;
  localparam int END_LINE = 42;
  localparam int BP       = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [9:0]  line_o, dot_o;
  logic [15:0] status_o;
  logic        frame_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  raster_timing #(.RETRACE_END(END_LINE), .BACK_PORCH(BP)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .line_o(line_o), .dot_o(dot_o), .status_o(status_o), .frame_o(frame_o)
  );

  typedef struct packed {
    logic [9:0]  line;
    logic [9:0]  dot;
    logic [15:0] status;
    logic        frame;
  } exp_t;
  exp_t sb_q[$];

  // reference model state
  int m_lmax, m_dmax, m_vs, m_hs, m_fp, m_line, m_dot;
  bit m_il, m_field;

  function automatic logic [15:0] ref_status(int ln, int dt, bit fld);
    logic [15:0] s = '0;
    s[9:0] = 10'(ln);
    s[10]  = fld;
    if (ln[0] == fld) begin
      s[12] = dt > (m_hs + 1) * 2;
      if (ln >= m_vs) begin s[13] = 1'b1; s[11] = dt > m_fp + 1; end
    end else begin
      s[12] = 1'b1;
      if (ln >= m_vs) begin s[13] = 1'b1; s[11] = (dt + BP) < (m_dmax + 1); end
    end
    return s;
  endfunction

  always @(posedge clk) begin
    exp_t e;
    if (rst) begin
      m_lmax = 624; m_dmax = 863; m_vs = 5; m_hs = 63; m_fp = 0; m_il = 0;
      m_line = 0; m_dot = 0; m_field = 0;
      sb_q.delete();
    end else begin
      e.status = ref_status(m_line, m_dot, m_field);
      e.frame  = 1'b0;
      if (wr_en && wr_sel == 2'd0) m_dot = 0;
      else if (m_dmax != 0) begin
        if (m_dot >= m_dmax) begin
          m_dot = 0;
          if (m_line >= m_lmax) begin m_line = 0; if (m_il) m_field = ~m_field; end
          else begin m_line++; e.frame = (m_line == END_LINE); end
        end else m_dot++;
      end
      if (wr_en) case (wr_sel)
        2'd0: begin m_lmax = int'(wr_data[25:16]); m_dmax = int'(wr_data[9:0]); end
        2'd1: m_il = wr_data[4];
        2'd2: begin m_vs = int'(wr_data[11:8]); m_hs = int'(wr_data[6:0]); end
        default: m_fp = int'(wr_data[9:0]);
      endcase
      e.line = 10'(m_line);
      e.dot  = 10'(m_dot);
      sb_q.push_back(e);
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    exp_t e;
    if (!rst && sb_q.size() > 0) begin
      e = sb_q.pop_front();
      vectors++;
      if (line_o !== e.line || dot_o !== e.dot) begin
        errors++;
        $display("FAIL R2 counters line/dot got %0d/%0d exp %0d/%0d", line_o, dot_o, e.line, e.dot);
      end
      if (status_o[10:0] !== e.status[10:0]) begin
        errors++;
        $display("FAIL R4 status low got %h exp %h", status_o, e.status);
      end
      if (status_o[15:11] !== e.status[15:11]) begin
        errors++;
        if (e.status[0] == e.status[10])
          $display("FAIL R5 matching-line regions got %h exp %h", status_o, e.status);
        else
          $display("FAIL R6 other-line regions got %h exp %h", status_o, e.status);
      end
      if (frame_o !== e.frame) begin
        errors++;
        $display("FAIL R7 strobe got %0b exp %0b", frame_o, e.frame);
      end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_count(int n, output int strobes, output int flips);
    logic prev_f;
    strobes = 0; flips = 0;
    prev_f = status_o[10];
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (frame_o) strobes++;
      if (status_o[10] != prev_f) flips++;
      prev_f = status_o[10];
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    int s, f, hold_line;
    repeat (3) @(negedge clk);
    // R1: outputs idle while reset is held
    check(line_o == 0 && dot_o == 0, "R1 reset counters", int'(dot_o), 0);
    check(status_o == 0 && frame_o == 0, "R1 reset status", int'(status_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check(status_o == 0, "R1 status after release", int'(status_o), 0);
    // R8: default line length is 864 dots
    repeat (863) @(negedge clk);
    check(line_o == 1 && dot_o == 0, "R8 default line length", int'(line_o), 1);

    // small interlaced raster: 50 lines of 16 dots, upper bits garbage (R2)
    wr(2'd1, 32'hFFFF_FC10);           // R3 interlace on
    wr(2'd2, 32'h0000_0302);           // vsync 3 lines, hsync 6 dots
    wr(2'd3, 32'h0000_0004);           // front porch 5 dots
    wr(2'd0, 32'hFC31_FC0F);
    check(dot_o == 0 && line_o == 1, "R9 total write zeroes dot", int'(dot_o), 0);
    run_count(3200, s, f);
    check(f == 4, "R3 field flips over four interlaced fields", f, 4);
    check(s == 4, "R7 strobes over four fields", s, 4);

    // interlace off
    wr(2'd1, 32'h0000_0000);
    run_count(1600, s, f);
    check(f == 0, "R3 field held without interlace", f, 0);
    check(s == 2, "R7 strobes over two fields", s, 2);

    // R9: mid-line rewrite keeps line
    repeat (7) @(negedge clk);
    hold_line = int'(line_o);
    wr(2'd0, 32'h0031_000F);
    check(dot_o == 0 && int'(line_o) == hold_line, "R9 line kept on total write", int'(line_o), hold_line);
    @(negedge clk);
    check(dot_o == 1, "R2 dot resumes after total write", int'(dot_o), 1);

    // R10: dot limit zero freezes
    wr(2'd0, 32'h0031_0000);
    hold_line = int'(line_o);
    repeat (20) @(negedge clk);
    check(dot_o == 0 && int'(line_o) == hold_line, "R10 frozen counters", int'(dot_o), 0);
    check(status_o[9:0] == 10'(hold_line), "R4 status line while frozen", int'(status_o[9:0]), hold_line);

    // restore and run a while with odd vsync setting
    wr(2'd2, 32'h0000_0F00);
    wr(2'd0, 32'h0031_0009);
    repeat (1200) @(negedge clk);
    done = 1'b1;
    finish_up();
  end
endmodule